// File: doc/BRIEF.md
# Enqueue Command Ring Consumer

This block is the hardware end of a small ring of enqueue commands that software fills. Software writes whole entries into a slot array through a byte-addressed write port, then makes them visible in one of three ways: it writes a producer index through an uncached path, writes it through a cached path, or leaves the index alone and marks each entry with a flag bit in its verb byte. In flag mode the hardware discovers new entries by itself, one slot per cycle. The meaning of the flag is inverted on every lap of the ring.

The consumer issues committed entries strictly in ring order on a valid/ready command output, at most one per cycle. It publishes its consumer index and reports the current fill and the free space that software may still use, always keeping one slot empty. A counter of issued but unacknowledged entries drives an interrupt against a programmable threshold. Software acknowledges by pulsing a write-one-to-clear input.

Top module: `enq_ring_consumer`

## Requirements
- R1: After reset the consumer and producer indices are 0, fill is 0, free space is 7, the command output is not valid and the interrupt is low.
- R2: With mode 0 a producer index write on the uncached path (path bit 0) sets the producer index, and with mode 1 a write on the cached path (path bit 1) does. A write on the other path leaves fill unchanged.
- R3: With mode 2 the slot at the producer index counts as committed when bit 7 of its verb byte (entry bits 7:0) equals the expected flag. The expected flag is 1 after reset and inverts each time the producer index wraps from 7 to 0. Index writes on either path are ignored in this mode.
- R4: Fill equals the producer index minus the consumer index modulo 8, and free space equals 7 minus fill.
- R5: The command output is valid exactly when fill is nonzero and carries the entry at the consumer index. Each accepted transfer advances the consumer index by one modulo 8. The consumer index is output as 3 bits.
- R6: While the command output is valid and not accepted, the consumer index and the command data stay unchanged.
- R7: In mode 2 the producer index never advances while fill is 7, so one slot is always empty.
- R8: A pending count increments on each accepted transfer and saturates at 31. The interrupt is high when the threshold is nonzero and the pending count is at or above it. A threshold of 0 keeps the interrupt low.
- R9: A clear pulse zeroes the pending count. A transfer accepted in the same cycle counts as 1 afterwards.
- R10: The write port slot is the byte address divided by 64 modulo 8 (address bits 8:6). Address bits 5:0 do not affect where the entry lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Producer mode: 0 uncached index, 1 cached index, 2 in-band flag |
| ent_we_i | input | 1 | Entry write strobe |
| ent_addr_i | input | ADDR_W (9) | Entry byte address |
| ent_data_i | input | ENTRY_W (16) | Entry contents, verb byte in bits 7:0 |
| pi_wr_i | input | 1 | Producer index write strobe |
| pi_path_i | input | 1 | Access path of the index write: 0 uncached, 1 cached |
| pi_val_i | input | IDX_W (3) | Producer index value |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_val_i | input | CNT_W (5) | Threshold value |
| irq_clr_i | input | 1 | Write-one-to-clear acknowledge |
| cmd_valid_o | output | 1 | Command output valid |
| cmd_ready_i | input | 1 | Command output ready |
| cmd_data_o | output | ENTRY_W (16) | Entry being issued |
| ci_o | output | IDX_W (3) | Consumer index |
| fill_o | output | FILL_W (4) | Committed entries not yet issued |
| avail_o | output | FILL_W (4) | Free slots for the producer |
| irq_o | output | 1 | Threshold interrupt |

## Verification
The bench builds the block with its defaults: 8 slots, 16-bit entries, a 5-bit pending counter and the flag variant enabled. With that ring size, both index modes can be swept over every fill level from 0 to 7 from several starting consumer positions, so every wrap of the index difference is exercised. More than 31 transfers drive the pending counter into saturation. Flag mode is driven through two laps, a stale entry and a full ring, which reaches the polarity inversion and the one-empty-slot limit.

// File: rtl/enq_ring_pkg.sv
`timescale 1ns/1ps
package enq_ring_pkg;
   typedef enum logic [1:0] {
      PM_IDX_UNCACHED = 2'd0,
      PM_IDX_CACHED   = 2'd1,
      PM_VALID_BIT    = 2'd2,
      PM_RSVD         = 2'd3
   } prod_mode_e;

   // verb byte flag position, used by the producer tracker
   localparam int VERB_FLAG_BIT = 7;
   // one ring slot spans 64 bytes of address space
   localparam int SLOT_SHIFT = 6;
endpackage

// File: rtl/erc_slot_array.sv
`timescale 1ns/1ps
module erc_slot_array
   import enq_ring_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int ENTRY_W = 16,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [IDX_W-1:0]   widx_i,
   input  logic [ENTRY_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]   rd_idx_i,
   output logic [ENTRY_W-1:0] rd_data_o,
   input  logic [IDX_W-1:0]   flag_idx_i,
   output logic               flag_o
);
   logic [ENTRY_W-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[g] <= '0;
         else if (we_i && (widx_i == IDX_W'(g)))
            slot_q[g] <= wdata_i;
      end
   end

   assign rd_data_o = slot_q[rd_idx_i];
   assign flag_o    = slot_q[flag_idx_i][VERB_FLAG_BIT];
endmodule

// File: rtl/erc_prod_track.sv
`timescale 1ns/1ps
module erc_prod_track
   import enq_ring_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter bit HAS_VB = 1'b1,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int FILL_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  prod_mode_e        mode_i,
   input  logic              idx_wr_i,
   input  logic              idx_path_i,
   input  logic [IDX_W-1:0]  idx_val_i,
   input  logic              head_flag_i,
   input  logic [IDX_W-1:0]  ci_i,
   output logic [IDX_W-1:0]  pi_o,
   output logic [FILL_W-1:0] fill_o
);
   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DEPTH - 1);
   localparam logic [FILL_W-1:0] FILL_CAP = FILL_W'(DEPTH - 1);

   logic [IDX_W-1:0] pi_q;
   logic             pol_q;
   logic             idx_hit;
   logic             vb_adv;

   assign idx_hit = idx_wr_i &&
                    ((mode_i == PM_IDX_UNCACHED && !idx_path_i) ||
                     (mode_i == PM_IDX_CACHED   &&  idx_path_i));

   assign fill_o = {1'b0, pi_q - ci_i};
   assign pi_o   = pi_q;

   if (HAS_VB) begin : g_vb
      assign vb_adv = (mode_i == PM_VALID_BIT) && (head_flag_i == pol_q) &&
                      (fill_o < FILL_CAP);
   end else begin : g_no_vb
      logic unused_flag;
      assign unused_flag = head_flag_i;
      assign vb_adv      = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pi_q  <= '0;
         pol_q <= 1'b1;
      end else if (idx_hit) begin
         pi_q <= idx_val_i;
      end else if (vb_adv) begin
         pi_q <= pi_q + IDX_W'(1);
         if (pi_q == LAST_IDX)
            pol_q <= ~pol_q;
      end
   end

   // R2: outside a matching index write the index modes hold the producer index
   p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == PM_IDX_UNCACHED && !(idx_wr_i && !idx_path_i)) ||
       (mode_i == PM_IDX_CACHED   && !(idx_wr_i &&  idx_path_i)))
      |=> $stable(pi_o));

   // R7: a full ring in flag mode never moves the producer index
   p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == PM_VALID_BIT && fill_o == FILL_CAP) |=> $stable(pi_o));
endmodule

// File: rtl/erc_irq_gen.sv
`timescale 1ns/1ps
module erc_irq_gen #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thr_we_i,
   input  logic [CNT_W-1:0] thr_val_i,
   input  logic             clr_i,
   input  logic             issue_i,
   output logic             irq_o
);
   localparam logic [CNT_W-1:0] PEND_MAX = '1;

   logic [CNT_W-1:0] pend_q;
   logic [CNT_W-1:0] thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         thr_q  <= '0;
      end else begin
         if (thr_we_i)
            thr_q <= thr_val_i;
         if (clr_i)
            pend_q <= CNT_W'(issue_i);
         else if (issue_i && pend_q != PEND_MAX)
            pend_q <= pend_q + CNT_W'(1);
      end
   end

   assign irq_o = (thr_q != '0) && (pend_q >= thr_q);

   // R8: each issue adds one below saturation
   p_pend_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !clr_i && pend_q != PEND_MAX) |=>
      pend_q == CNT_W'($past(pend_q) + CNT_W'(1)));

   // R8: saturation holds without a clear
   p_pend_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == PEND_MAX && !clr_i) |=> pend_q == PEND_MAX);

   // R9: a clear leaves at most the same-cycle issue
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> pend_q <= CNT_W'(1));
endmodule

// File: rtl/enq_ring_consumer.sv
`timescale 1ns/1ps
module enq_ring_consumer
   import enq_ring_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int ENTRY_W = 16,
   parameter int CNT_W   = 5,
   parameter bit HAS_VB  = 1'b1,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int ADDR_W = IDX_W + SLOT_SHIFT,
   localparam int FILL_W = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode_i,
   input  logic               ent_we_i,
   input  logic [ADDR_W-1:0]  ent_addr_i,
   input  logic [ENTRY_W-1:0] ent_data_i,
   input  logic               pi_wr_i,
   input  logic               pi_path_i,
   input  logic [IDX_W-1:0]   pi_val_i,
   input  logic               thr_we_i,
   input  logic [CNT_W-1:0]   thr_val_i,
   input  logic               irq_clr_i,
   output logic               cmd_valid_o,
   input  logic               cmd_ready_i,
   output logic [ENTRY_W-1:0] cmd_data_o,
   output logic [IDX_W-1:0]   ci_o,
   output logic [FILL_W-1:0]  fill_o,
   output logic [FILL_W-1:0]  avail_o,
   output logic               irq_o
);
   localparam logic [FILL_W-1:0] FILL_CAP = FILL_W'(DEPTH - 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (ENTRY_W < 8) begin : g_bad_width
      $error("ENTRY_W must hold a full verb byte");
   end
   if (CNT_W <= IDX_W) begin : g_bad_cnt
      $error("CNT_W must exceed the index width");
   end

   prod_mode_e       mode;
   logic [IDX_W-1:0] ci_q;
   logic [IDX_W-1:0] pi;
   logic             head_flag;
   logic             fire;
   logic [SLOT_SHIFT-1:0] unused_addr_lo;

   assign mode           = prod_mode_e'(mode_i);
   assign unused_addr_lo = ent_addr_i[SLOT_SHIFT-1:0];

   erc_slot_array #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (ent_we_i),
      .widx_i     (ent_addr_i[ADDR_W-1:SLOT_SHIFT]),
      .wdata_i    (ent_data_i),
      .rd_idx_i   (ci_q),
      .rd_data_o  (cmd_data_o),
      .flag_idx_i (pi),
      .flag_o     (head_flag)
   );

   erc_prod_track #(.DEPTH(DEPTH), .HAS_VB(HAS_VB)) u_prod (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode),
      .idx_wr_i    (pi_wr_i),
      .idx_path_i  (pi_path_i),
      .idx_val_i   (pi_val_i),
      .head_flag_i (head_flag),
      .ci_i        (ci_q),
      .pi_o        (pi),
      .fill_o      (fill_o)
   );

   erc_irq_gen #(.CNT_W(CNT_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .thr_we_i  (thr_we_i),
      .thr_val_i (thr_val_i),
      .clr_i     (irq_clr_i),
      .issue_i   (fire),
      .irq_o     (irq_o)
   );

   assign cmd_valid_o = (fill_o != '0);
   assign fire        = cmd_valid_o && cmd_ready_i;
   assign avail_o     = FILL_CAP - fill_o;
   assign ci_o        = ci_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ci_q <= '0;
      else if (fire)
         ci_q <= ci_q + IDX_W'(1);
   end

   // R5: one accepted transfer moves the consumer index by exactly one
   p_ci_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> ci_o == IDX_W'($past(ci_o) + IDX_W'(1)));

   // R6: a stalled command keeps its slot
   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && !cmd_ready_i) |=> $stable(ci_o));

   // R5: nothing is accepted from an empty ring
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_o == '0) |=> $stable(ci_o));
endmodule

// File: tb/sim_enq_ring_consumer.sv
`timescale 1ns/1ps
module sim_enq_ring_consumer;
   localparam int DEPTH = 8, ENTRY_W = 16, CNT_W = 5;
   localparam int IDX_W = 3, ADDR_W = 9, FILL_W = 4, PMAX = 31;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic ent_we = 1'b0;
   logic [ADDR_W-1:0] ent_addr = '0;
   logic [ENTRY_W-1:0] ent_data = '0;
   logic pi_wr = 1'b0, pi_path = 1'b0;
   logic [IDX_W-1:0] pi_val = '0;
   logic thr_we = 1'b0;
   logic [CNT_W-1:0] thr_val = '0;
   logic irq_clr = 1'b0, cmd_ready = 1'b0;
   logic cmd_valid, irq;
   logic [ENTRY_W-1:0] cmd_data;
   logic [IDX_W-1:0] ci;
   logic [FILL_W-1:0] fill, avail;

   int n_cmp = 0, n_bad = 0;
   int m_ci = 0, m_pi = 0, pend = 0, thr = 0;
   logic [ENTRY_W-1:0] tb_mem [DEPTH];

   always #2.5 clk = ~clk;

   enq_ring_consumer u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .ent_we_i(ent_we),
      .ent_addr_i(ent_addr), .ent_data_i(ent_data), .pi_wr_i(pi_wr),
      .pi_path_i(pi_path), .pi_val_i(pi_val), .thr_we_i(thr_we),
      .thr_val_i(thr_val), .irq_clr_i(irq_clr), .cmd_valid_o(cmd_valid),
      .cmd_ready_i(cmd_ready), .cmd_data_o(cmd_data), .ci_o(ci),
      .fill_o(fill), .avail_o(avail), .irq_o(irq)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      tick();
      m_ci = 0; m_pi = 0; pend = 0; thr = 0;
      for (int i = 0; i < DEPTH; i++) tb_mem[i] = '0;
   endtask

   // R10: junk in the low address bits must not move the entry
   task automatic wr_entry(input int idx, input logic [ENTRY_W-1:0] d);
      ent_we   = 1'b1;
      ent_addr = {3'(idx), 6'((idx * 13 + 5) % 64)};
      ent_data = d;
      tick();
      ent_we = 1'b0;
      tb_mem[idx] = d;
   endtask

   task automatic set_pi(input int path, input int v);
      pi_wr = 1'b1; pi_path = path[0]; pi_val = 3'(v);
      tick();
      pi_wr = 1'b0;
   endtask

   task automatic set_thr(input int v);
      thr_we = 1'b1; thr_val = 5'(v);
      tick();
      thr_we = 1'b0;
      thr = v;
   endtask

   task automatic chk_levels(input string req, input int exp_fill);
      chk({req, " fill"}, int'(fill), exp_fill);
      chk({req, " avail"}, int'(avail), 7 - exp_fill);
      chk({req, " ci"}, int'(ci), m_ci);
      chk({req, " valid"}, int'(cmd_valid), (exp_fill != 0) ? 1 : 0);
   endtask

   task automatic chk_irq(input string req);
      chk(req, int'(irq), (thr != 0 && pend >= thr) ? 1 : 0);
   endtask

   task automatic drain(input string req);
      int guard = 0;
      cmd_ready = 1'b1;
      while (cmd_valid && guard < 20) begin
         chk(req, int'(cmd_data), int'(tb_mem[m_ci]));
         tick();
         m_ci = (m_ci + 1) % DEPTH;
         if (pend < PMAX) pend++;
         guard++;
      end
      cmd_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      do_reset();
      // R1: reset state
      chk_levels("R1", 0);
      chk("R1 irq", int'(irq), 0);

      set_thr(5);
      // R2 R4 R5 R10: index modes, every fill level from many ci starts
      for (int m = 0; m < 2; m++) begin
         mode = 2'(m);
         for (int rep = 0; rep < 2; rep++) begin
            for (int n = 0; n < DEPTH; n++) begin
               for (int i = 0; i < n; i++)
                  wr_entry((m_pi + i) % DEPTH, {8'(m * 128 + n * 16 + i), 8'(i * 37)});
               set_pi(1 - m, (m_ci + n + 3) % DEPTH);
               chk_levels("R2 wrong path", 0);
               set_pi(m, (m_ci + n) % DEPTH);
               m_pi = (m_ci + n) % DEPTH;
               chk_levels("R2 R4", n);
               if (n >= 2) begin
                  logic [ENTRY_W-1:0] d0;
                  d0 = cmd_data;
                  idle(3);
                  chk("R6 data", int'(cmd_data), int'(d0));
                  chk("R6 ci", int'(ci), m_ci);
               end
               drain("R5 R10 order");
               chk_levels("R4 drained", 0);
               chk_irq("R8 level");
            end
         end
      end
      chk("R8 saturated irq", int'(irq), 1);

      // R9: clear
      irq_clr = 1'b1; tick(); irq_clr = 1'b0; pend = 0;
      chk_irq("R9 cleared");

      // R9: clear together with an issue; R8 threshold compare
      set_thr(2);
      wr_entry(m_pi, 16'hA1B2);
      wr_entry((m_pi + 1) % DEPTH, 16'hC3D4);
      set_pi(1, (m_pi + 2) % DEPTH);
      m_pi = (m_pi + 2) % DEPTH;
      cmd_ready = 1'b1; irq_clr = 1'b1;
      chk("R5 data", int'(cmd_data), int'(tb_mem[m_ci]));
      tick();
      irq_clr = 1'b0; m_ci = (m_ci + 1) % DEPTH; pend = 1;
      chk_irq("R9 clear with issue");
      chk("R5 data", int'(cmd_data), int'(tb_mem[m_ci]));
      tick();
      cmd_ready = 1'b0; m_ci = (m_ci + 1) % DEPTH; pend = 2;
      chk_irq("R8 at threshold");
      chk("R8 at threshold high", int'(irq), 1);
      set_thr(0);
      chk("R8 zero threshold", int'(irq), 0);

      // R3: flag mode after a fresh reset
      do_reset();
      mode = 2'd2;
      for (int i = 0; i < 3; i++) wr_entry(i, {8'(8'h10 + i), 8'h80 | 8'(i)});
      wr_entry(3, {8'h13, 8'h03});
      idle(6);
      chk_levels("R3 flag commit", 3);
      set_pi(0, 6);
      set_pi(1, 6);
      chk_levels("R3 index write ignored", 3);
      drain("R3 R5 order");
      chk_levels("R3 stale entry", 0);

      for (int i = 3; i < DEPTH; i++) wr_entry(i, {8'(8'h20 + i), 8'h80 | 8'(i)});
      idle(8);
      chk_levels("R3 wrap stops at old flag", 5);

      wr_entry(0, {8'h30, 8'h00});
      wr_entry(1, {8'h31, 8'h01});
      idle(6);
      chk_levels("R3 inverted flag", 7);
      wr_entry(2, {8'h32, 8'h02});
      idle(6);
      chk_levels("R7 full ring", 7);

      cmd_ready = 1'b1;
      chk("R5 data", int'(cmd_data), int'(tb_mem[m_ci]));
      tick();
      cmd_ready = 1'b0; m_ci = (m_ci + 1) % DEPTH;
      idle(4);
      chk_levels("R7 refill after one", 7);
      drain("R5 flag order");
      chk_levels("R3 second lap stale", 0);
      wr_entry(3, {8'h33, 8'h03});
      idle(4);
      chk_levels("R3 second lap commit", 1);

      summary();
      $finish;
   end
endmodule